// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block watches the control pins of a four-bank synchronous DRAM and, on every rising clock edge, works out which command the controller issued. It reports the command by name, the state of every bank (idle, open, or closing with a countdown), a flag for commands that the current state does not allow, and which low-power or clock-hold condition the device is in. It moves no data and models no storage. It is meant to sit next to a memory controller as a protocol monitor, or inside a memory model as its command front end.

The legality of a command depends on the state of the bank it names and on whether every bank is idle. The A10 pin turns a read or write into its auto-closing form and a single-bank close into a close of all banks. The level of the clock-enable pin at the edge, compared with the power state entered at the previous edge, selects between normal operation, power-down, self-refresh and clock hold. Bank close time (`RP_CYC`), auto-close time (`AP_CYC`) and refresh/self-refresh recovery time (`RC_CYC`) are parameters counted in clock cycles, each at least 2.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With chip select low, clock enable high and the block in run mode, the pins {rasN,casN,weN} decode as 111 NOP, 011 ACT, 101 READ, 100 WRITE, 110 TERM, 010 PRE, 001 REFA, 000 MRS. The decoded command appears on cmdOut after the edge that samples it, using the encoding DESEL=0, NOP=1, ACT=2, READ=3, READA=4, WRITE=5, WRITEA=6, PRE=7, PREA=8, TERM=9, MRS=10, REFA=11, SREF=12, PDEN=13, WAKE=14, HOLD=15.
- R2: With a10 high, READ becomes READA, WRITE becomes WRITEA, and PRE becomes PREA. PREA closes every open bank.
- R3: ACT to an idle bank makes that bank open. ACT to a bank that is open or closing raises illegal and leaves the bank unchanged. bankState holds 2 bits per bank at [2*b+1:2*b], with 0=idle, 1=open and 2=closing.
- R4: READ or WRITE to a bank that is not open raises illegal. READA or WRITEA to an open bank puts it into the closing state, and the bank is idle again AP_CYC edges after the command. An ACT before that edge is illegal.
- R5: PRE to an open bank puts it into the closing state, and the bank reads idle after edge t+RP_CYC-1, where t is the edge of the PRE. PRE to a bank that is idle or already closing is legal and has no effect.
- R6: MRS and REFA raise illegal unless every bank is idle. A legal REFA puts every bank into the closing state for RC_CYC cycles.
- R7: Clock enable low in run mode with every bank idle gives SREF (pwrMode 2) when the pins carry the refresh pattern. Otherwise it gives PDEN with power-down (pwrMode 1), and illegal is raised if the pins carried anything other than NOP or DESEL.
- R8: Clock enable low in run mode with any bank not idle executes the command at that edge and enters clock hold (pwrMode 3). While clock enable stays low in power-down, self-refresh or clock hold, cmdOut is HOLD, the pins have no effect on any bank, and closing countdowns keep running.
- R9: Clock enable high in power-down or clock hold returns the block to run mode (pwrMode 0) with cmdOut WAKE. The pins at that edge are ignored.
- R10: Clock enable high in self-refresh gives WAKE and a recovery mode (pwrMode 4) lasting RC_CYC-1 edges. In this mode any command other than NOP or DESEL raises illegal and is ignored. Run mode is reached after the last of those edges.
- R11: During reset, cmdOut is NOP, illegal is low, every bank is idle, and pwrMode is 0.
- R12: Chip select high decodes as DESEL whatever the other pins carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all pins are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable level at this edge |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Auto-close / all-bank select |
| cmdOut | output | 4 | Decoded command (encoding in R1) |
| bankState | output | 2*NUM_BANKS (8) | Per-bank state (encoding in R3) |
| illegal | output | 1 | The command at the last edge was not allowed |
| pwrMode | output | 3 | 0 run, 1 power-down, 2 self-refresh, 3 clock hold, 4 self-refresh recovery |

## Verification
A directed sequence takes each bank through opening, using and closing, and tries every command both against a bank or state that accepts it and against one that refuses it. This separates decode errors from legality errors. Clock-enable falls are applied with all banks idle (with refresh pins, NOP pins and a real command) and with a bank open or closing, which separates power-down, self-refresh entry and clock hold. Commands are offered during each hold and at each wake edge to show they are ignored. A long random mix of commands, bank addresses, A10 and clock-enable drops then runs against the bench's behavioural model, which compares the command, the flag, all bank states and the power mode on every cycle. This catches countdowns that are off by one cycle and commands that leak through a hold.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL  = 4'd0,
    CMD_NOP    = 4'd1,
    CMD_ACT    = 4'd2,
    CMD_READ   = 4'd3,
    CMD_READA  = 4'd4,
    CMD_WRITE  = 4'd5,
    CMD_WRITEA = 4'd6,
    CMD_PRE    = 4'd7,
    CMD_PREA   = 4'd8,
    CMD_TERM   = 4'd9,
    CMD_MRS    = 4'd10,
    CMD_REFA   = 4'd11,
    CMD_SREF   = 4'd12,
    CMD_PDEN   = 4'd13,
    CMD_WAKE   = 4'd14,
    CMD_HOLD   = 4'd15
  } cmd_e;

  typedef enum logic [1:0] {
    BANK_IDLE   = 2'd0,
    BANK_ACTIVE = 2'd1,
    BANK_PRECH  = 2'd2
  } bank_e;

  typedef enum logic [2:0] {
    MODE_RUN   = 3'd0,
    MODE_PDOWN = 3'd1,
    MODE_SELF  = 3'd2,
    MODE_SUSP  = 3'd3,
    MODE_SRXW  = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    CLOSE_PRE  = 2'd0,
    CLOSE_AUTO = 2'd1,
    CLOSE_REF  = 2'd2
  } close_e;

  // Strobes from control to the bank datapath, one per bank
  typedef struct packed {
    logic   doOpen;
    logic   doClose;
    close_e kind;
  } bankCtl_t;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic csN,
  input  logic rasN,
  input  logic casN,
  input  logic weN,
  input  logic a10,
  output cmd_e pinCmd
);

  // Pin pattern to command, valid for the clock-enable-high case
  always_comb begin
    if (csN) begin
      pinCmd = CMD_DESEL;
    end else begin
      case ({rasN, casN, weN})
        3'b111:  pinCmd = CMD_NOP;
        3'b011:  pinCmd = CMD_ACT;
        3'b101:  pinCmd = a10 ? CMD_READA : CMD_READ;
        3'b100:  pinCmd = a10 ? CMD_WRITEA : CMD_WRITE;
        3'b010:  pinCmd = a10 ? CMD_PREA : CMD_PRE;
        3'b110:  pinCmd = CMD_TERM;
        3'b001:  pinCmd = CMD_REFA;
        default: pinCmd = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_array.sv
module sdram_bank_array
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int RP_CYC    = 3,
  parameter int RC_CYC    = 6,
  parameter int AP_CYC    = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bankCtl_t [NUM_BANKS-1:0] ctl,
  output bank_e    [NUM_BANKS-1:0] bankSt
);

  localparam int MAX_CYC = (RP_CYC > RC_CYC) ? ((RP_CYC > AP_CYC) ? RP_CYC : AP_CYC)
                                             : ((RC_CYC > AP_CYC) ? RC_CYC : AP_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RC_CYC - 1);
  localparam logic [CNT_W-1:0] AP_LOAD = CNT_W'(AP_CYC - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_e            stQ;
    logic [CNT_W-1:0] cntQ;
    logic [CNT_W-1:0] loadVal;

    always_comb begin
      case (ctl[b].kind)
        CLOSE_AUTO: loadVal = AP_LOAD;
        CLOSE_REF:  loadVal = RC_LOAD;
        default:    loadVal = RP_LOAD;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ  <= BANK_IDLE;
        cntQ <= '0;
      end else if (ctl[b].doOpen) begin
        stQ  <= BANK_ACTIVE;
        cntQ <= '0;
      end else if (ctl[b].doClose) begin
        stQ  <= BANK_PRECH;
        cntQ <= loadVal;
      end else if (stQ == BANK_PRECH) begin
        if (cntQ <= CNT_W'(1)) begin
          stQ  <= BANK_IDLE;
          cntQ <= '0;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end

    assign bankSt[b] = stQ;

    // R5: a closing bank never jumps straight back to open
    a_r5_prech_not_open: assert property (@(posedge clk) disable iff (!rstN)
      (stQ == BANK_PRECH && !ctl[b].doClose) |=> (stQ != BANK_ACTIVE));

    // R5: an idle bank with no strobe stays idle
    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
      (stQ == BANK_IDLE && !ctl[b].doOpen && !ctl[b].doClose) |=> (stQ == BANK_IDLE));
  end

endmodule

// File: rtl/sdram_trk_ctrl.sv
module sdram_trk_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int RC_CYC    = 6,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cke,
  input  logic [BA_W-1:0]          ba,
  input  cmd_e                     pinCmd,
  input  bank_e    [NUM_BANKS-1:0] bankSt,
  output bankCtl_t [NUM_BANKS-1:0] ctl,
  output cmd_e                     cmdQ,
  output logic                     illegalQ,
  output mode_e                    modeQ
);

  localparam int SRX_W = $clog2(RC_CYC + 1);
  localparam logic [SRX_W-1:0] SRX_LOAD = SRX_W'(RC_CYC - 1);

  logic             allIdle;
  logic             pinQuiet;
  logic [SRX_W-1:0] srxCnt;
  logic [SRX_W-1:0] srxN;
  cmd_e             cmdN;
  logic             illN;
  mode_e            modeN;

  always_comb begin
    allIdle = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankSt[b] != BANK_IDLE) allIdle = 1'b0;
    end
  end

  assign pinQuiet = (pinCmd == CMD_NOP) || (pinCmd == CMD_DESEL);

  always_comb begin
    ctl   = '0;
    cmdN  = CMD_HOLD;
    illN  = 1'b0;
    modeN = modeQ;
    srxN  = srxCnt;
    case (modeQ)
      MODE_RUN: begin
        if (!cke && allIdle) begin
          if (pinCmd == CMD_REFA) begin
            cmdN  = CMD_SREF;
            modeN = MODE_SELF;
          end else begin
            cmdN  = CMD_PDEN;
            modeN = MODE_PDOWN;
            illN  = !pinQuiet;
          end
        end else begin
          cmdN = pinCmd;
          case (pinCmd)
            CMD_ACT: begin
              if (bankSt[ba] == BANK_IDLE) ctl[ba].doOpen = 1'b1;
              else                         illN = 1'b1;
            end
            CMD_READ, CMD_WRITE: begin
              if (bankSt[ba] != BANK_ACTIVE) illN = 1'b1;
            end
            CMD_READA, CMD_WRITEA: begin
              if (bankSt[ba] == BANK_ACTIVE) begin
                ctl[ba].doClose = 1'b1;
                ctl[ba].kind    = CLOSE_AUTO;
              end else begin
                illN = 1'b1;
              end
            end
            CMD_PRE: begin
              if (bankSt[ba] == BANK_ACTIVE) begin
                ctl[ba].doClose = 1'b1;
                ctl[ba].kind    = CLOSE_PRE;
              end
            end
            CMD_PREA: begin
              for (int b = 0; b < NUM_BANKS; b++) begin
                if (bankSt[b] == BANK_ACTIVE) begin
                  ctl[b].doClose = 1'b1;
                  ctl[b].kind    = CLOSE_PRE;
                end
              end
            end
            CMD_REFA: begin
              if (allIdle) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                  ctl[b].doClose = 1'b1;
                  ctl[b].kind    = CLOSE_REF;
                end
              end else begin
                illN = 1'b1;
              end
            end
            CMD_MRS: illN = !allIdle;
            default: ;
          endcase
          if (!cke) modeN = MODE_SUSP;
        end
      end
      MODE_PDOWN, MODE_SUSP: begin
        if (cke) begin
          cmdN  = CMD_WAKE;
          modeN = MODE_RUN;
        end
      end
      MODE_SELF: begin
        if (cke) begin
          cmdN = CMD_WAKE;
          if (RC_CYC > 1) begin
            modeN = MODE_SRXW;
            srxN  = SRX_LOAD;
          end else begin
            modeN = MODE_RUN;
          end
        end
      end
      MODE_SRXW: begin
        cmdN = pinCmd;
        illN = !pinQuiet;
        srxN = srxCnt - 1'b1;
        if (srxCnt <= SRX_W'(1)) modeN = MODE_RUN;
      end
      default: modeN = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ     <= CMD_NOP;
      illegalQ <= 1'b0;
      modeQ    <= MODE_RUN;
      srxCnt   <= '0;
    end else begin
      cmdQ     <= cmdN;
      illegalQ <= illN;
      modeQ    <= modeN;
      srxCnt   <= srxN;
    end
  end

  // R6: an accepted MRS implies every bank was idle before it
  a_r6_mrs_needs_idle: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_MRS && !illegalQ) |-> $past(allIdle));

  // R7: self-refresh and power-down are entered only from all-idle
  a_r7_self_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeQ == MODE_SELF) |-> $past(allIdle));
  a_r7_pdown_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeQ == MODE_PDOWN) |-> $past(allIdle));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R3: a bank opens only by an accepted ACT on an idle bank
    a_r3_open_by_act: assert property (@(posedge clk) disable iff (!rstN)
      $rose(bankSt[b] == BANK_ACTIVE) |-> (cmdQ == CMD_ACT && !illegalQ && $past(bankSt[b]) == BANK_IDLE));

    // R8: no bank opens while the clock is held or the part sleeps
    a_r8_hold_no_open: assert property (@(posedge clk) disable iff (!rstN)
      ((modeQ == MODE_PDOWN || modeQ == MODE_SELF || modeQ == MODE_SUSP) && bankSt[b] != BANK_ACTIVE)
        |=> (bankSt[b] != BANK_ACTIVE));

    // R10: self-refresh recovery leaves idle banks idle
    a_r10_recovery_idle: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ == MODE_SRXW && bankSt[b] == BANK_IDLE) |=> (bankSt[b] == BANK_IDLE));
  end

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int RP_CYC    = 3,
  parameter int RC_CYC    = 6,
  parameter int AP_CYC    = 5,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   rasN,
  input  logic                   casN,
  input  logic                   weN,
  input  logic                   cke,
  input  logic [BA_W-1:0]        ba,
  input  logic                   a10,
  output logic [3:0]             cmdOut,
  output logic [2*NUM_BANKS-1:0] bankState,
  output logic                   illegal,
  output logic [2:0]             pwrMode
);

  cmd_e                     pinCmd;
  cmd_e                     cmdQ;
  mode_e                    modeQ;
  bankCtl_t [NUM_BANKS-1:0] ctl;
  bank_e    [NUM_BANKS-1:0] bankSt;

  sdram_cmd_decode u_decode (
    .csN    (csN),
    .rasN   (rasN),
    .casN   (casN),
    .weN    (weN),
    .a10    (a10),
    .pinCmd (pinCmd)
  );

  sdram_trk_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .RC_CYC    (RC_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .ba       (ba),
    .pinCmd   (pinCmd),
    .bankSt   (bankSt),
    .ctl      (ctl),
    .cmdQ     (cmdQ),
    .illegalQ (illegal),
    .modeQ    (modeQ)
  );

  sdram_bank_array #(
    .NUM_BANKS (NUM_BANKS),
    .RP_CYC    (RP_CYC),
    .RC_CYC    (RC_CYC),
    .AP_CYC    (AP_CYC)
  ) u_banks (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .bankSt (bankSt)
  );

  assign cmdOut  = cmdQ;
  assign pwrMode = modeQ;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bankState[2*b +: 2] = bankSt[b];
    end
  end

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;
  import sdram_trk_pkg::*;

  localparam int NB = 4;
  localparam int RP = 3;
  localparam int RC = 6;
  localparam int AP = 5;

  logic clk = 1'b0;
  logic rstN;
  logic csN, rasN, casN, weN, cke, a10;
  logic [1:0] ba;
  logic [3:0] cmdOut;
  logic [2*NB-1:0] bankState;
  logic illegal;
  logic [2:0] pwrMode;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  int mBank[NB];
  int mCnt[NB];
  int mMode;
  int mSrx;
  int eCmd;
  bit eIll;

  always #10 clk = ~clk;

  sdram_cmd_tracker #(.NUM_BANKS(NB), .RP_CYC(RP), .RC_CYC(RC), .AP_CYC(AP)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .ba(ba), .a10(a10), .cmdOut(cmdOut), .bankState(bankState),
    .illegal(illegal), .pwrMode(pwrMode)
  );

  function automatic int pinsToCmd(logic s, logic r, logic c, logic w, logic a);
    if (s) return int'(CMD_DESEL);
    if (r && c && w) return int'(CMD_NOP);
    if (!r && c && w) return int'(CMD_ACT);
    if (r && !c && w) return a ? int'(CMD_READA) : int'(CMD_READ);
    if (r && !c && !w) return a ? int'(CMD_WRITEA) : int'(CMD_WRITE);
    if (!r && c && !w) return a ? int'(CMD_PREA) : int'(CMD_PRE);
    if (r && c && !w) return int'(CMD_TERM);
    if (!r && !c && w) return int'(CMD_REFA);
    return int'(CMD_MRS);
  endfunction

  function automatic logic [2*NB-1:0] packBanks();
    logic [2*NB-1:0] v;
    for (int b = 0; b < NB; b++) v[2*b +: 2] = 2'(mBank[b]);
    return v;
  endfunction

  task automatic modelEdge();
    int nb[NB];
    int nc[NB];
    bit idleAll = 1'b1;
    int pc;
    bit quiet;
    pc = pinsToCmd(csN, rasN, casN, weN, a10);
    quiet = (pc == int'(CMD_NOP)) || (pc == int'(CMD_DESEL));
    for (int b = 0; b < NB; b++) begin
      if (mBank[b] != 0) idleAll = 1'b0;
      nb[b] = mBank[b];
      nc[b] = mCnt[b];
      if (mBank[b] == 2) begin
        if (mCnt[b] <= 1) begin nb[b] = 0; nc[b] = 0; end
        else nc[b] = mCnt[b] - 1;
      end
    end
    eIll = 1'b0;
    eCmd = int'(CMD_HOLD);
    if (mMode == 0) begin
      if (!cke && idleAll) begin
        if (pc == int'(CMD_REFA)) begin eCmd = int'(CMD_SREF); mMode = 2; end
        else begin eCmd = int'(CMD_PDEN); mMode = 1; eIll = !quiet; end
      end else begin
        eCmd = pc;
        if (pc == int'(CMD_ACT)) begin
          if (mBank[ba] == 0) nb[ba] = 1; else eIll = 1'b1;
        end else if (pc == int'(CMD_READ) || pc == int'(CMD_WRITE)) begin
          if (mBank[ba] != 1) eIll = 1'b1;
        end else if (pc == int'(CMD_READA) || pc == int'(CMD_WRITEA)) begin
          if (mBank[ba] == 1) begin nb[ba] = 2; nc[ba] = AP - 1; end else eIll = 1'b1;
        end else if (pc == int'(CMD_PRE)) begin
          if (mBank[ba] == 1) begin nb[ba] = 2; nc[ba] = RP - 1; end
        end else if (pc == int'(CMD_PREA)) begin
          for (int b = 0; b < NB; b++) if (mBank[b] == 1) begin nb[b] = 2; nc[b] = RP - 1; end
        end else if (pc == int'(CMD_REFA)) begin
          if (idleAll) begin
            for (int b = 0; b < NB; b++) begin nb[b] = 2; nc[b] = RC - 1; end
          end else eIll = 1'b1;
        end else if (pc == int'(CMD_MRS)) begin
          eIll = !idleAll;
        end
        if (!cke) mMode = 3;
      end
    end else if (mMode == 1 || mMode == 3) begin
      if (cke) begin eCmd = int'(CMD_WAKE); mMode = 0; end
    end else if (mMode == 2) begin
      if (cke) begin eCmd = int'(CMD_WAKE); mMode = 4; mSrx = RC - 1; end
    end else begin
      eCmd = pc;
      eIll = !quiet;
      if (mSrx <= 1) mMode = 0;
      mSrx = mSrx - 1;
    end
    for (int b = 0; b < NB; b++) begin mBank[b] = nb[b]; mCnt[b] = nc[b]; end
  endtask

  task automatic compareAll(string req);
    checks++;
    if (cmdOut !== 4'(eCmd) || illegal !== eIll || bankState !== packBanks() || pwrMode !== 3'(mMode)) begin
      errors++;
      $display("FAIL %s: got cmd=%0d ill=%0b banks=%h mode=%0d, expected cmd=%0d ill=%0b banks=%h mode=%0d",
               req, cmdOut, illegal, bankState, pwrMode, eCmd, eIll, packBanks(), mMode);
    end
  endtask

  // Inputs are applied after a falling edge, outputs checked at the next one
  task automatic drive(logic s, logic r, logic c, logic w, logic k, logic [1:0] b, logic a, string req);
    csN = s; rasN = r; casN = c; weN = w; cke = k; ba = b; a10 = a;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll(req);
  endtask

  task automatic nops(int n, string req);
    for (int i = 0; i < n; i++) drive(0, 1, 1, 1, 1, 0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin mBank[b] = 0; mCnt[b] = 0; end
    mMode = 0; mSrx = 0; eCmd = int'(CMD_NOP); eIll = 1'b0;
    rstN = 1'b0; csN = 0; rasN = 1; casN = 1; weN = 1; cke = 1; ba = 0; a10 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll("R11 reset state");
    rstN = 1'b1;

    drive(1, 0, 0, 0, 1, 2, 1, "R12 deselect");
    drive(0, 0, 1, 1, 1, 0, 0, "R1 ACT bank0");
    drive(0, 0, 1, 1, 1, 0, 0, "R3 ACT open bank");
    drive(0, 1, 0, 1, 1, 1, 0, "R4 READ idle bank");
    drive(0, 1, 0, 1, 1, 0, 0, "R1 READ");
    drive(0, 1, 0, 0, 1, 0, 0, "R1 WRITE");
    drive(0, 1, 1, 0, 1, 0, 0, "R1 TERM");
    drive(0, 0, 0, 0, 1, 0, 0, "R6 MRS busy");
    drive(0, 0, 0, 1, 1, 0, 0, "R6 REFA busy");
    drive(0, 0, 1, 1, 1, 2, 0, "R3 ACT bank2");
    drive(0, 1, 0, 1, 1, 2, 1, "R2 READA");
    drive(0, 0, 1, 1, 1, 2, 0, "R4 ACT while auto-closing");
    nops(5, "R4 auto-close countdown");
    drive(0, 0, 1, 0, 1, 0, 0, "R5 PRE bank0");
    drive(0, 0, 1, 0, 1, 3, 0, "R5 PRE idle bank");
    nops(3, "R5 close countdown");
    drive(0, 0, 1, 1, 1, 1, 0, "R3 ACT bank1");
    drive(0, 0, 1, 1, 1, 3, 0, "R3 ACT bank3");
    drive(0, 1, 0, 0, 1, 3, 1, "R2 WRITEA");
    drive(0, 0, 1, 0, 1, 0, 1, "R2 PREA");
    nops(5, "R5 PREA countdown");
    drive(0, 0, 0, 0, 1, 0, 0, "R6 MRS idle");
    drive(0, 0, 0, 1, 1, 0, 0, "R6 REFA idle");
    drive(0, 0, 1, 1, 1, 0, 0, "R6 ACT during refresh");
    nops(6, "R6 refresh recovery");
    drive(0, 1, 1, 1, 0, 0, 0, "R7 power-down entry");
    drive(0, 0, 1, 1, 0, 0, 0, "R8 ACT ignored in power-down");
    drive(0, 0, 1, 1, 1, 0, 0, "R9 wake ignores ACT");
    nops(1, "R9 back to run");
    drive(0, 0, 1, 1, 0, 1, 0, "R7 command on power-down entry");
    drive(0, 1, 1, 1, 1, 0, 0, "R9 wake");
    drive(0, 0, 0, 1, 0, 0, 0, "R7 self-refresh entry");
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 1, 0, 0, 0, "R8 ACT ignored in self-refresh");
    drive(0, 1, 1, 1, 1, 0, 0, "R10 self-refresh exit");
    for (int i = 0; i < 7; i++) drive(0, 0, 1, 1, 1, 0, 0, "R10 ACT across recovery");
    drive(0, 0, 1, 1, 1, 1, 0, "R3 ACT bank1");
    drive(0, 1, 0, 1, 0, 1, 0, "R8 READ on suspend entry");
    drive(0, 0, 1, 0, 0, 1, 0, "R8 PRE ignored in hold");
    drive(0, 0, 1, 0, 1, 1, 0, "R9 wake from hold");
    drive(0, 0, 1, 0, 1, 1, 0, "R5 PRE bank1");
    drive(0, 1, 1, 1, 0, 0, 0, "R8 hold while closing");
    drive(0, 1, 1, 1, 0, 0, 0, "R8 countdown runs in hold");
    drive(0, 1, 1, 1, 1, 0, 0, "R9 wake");
    nops(4, "R5 settle");

    for (int i = 0; i < 1500; i++) begin
      logic [2:0] pat;
      pat = 3'($urandom_range(0, 7));
      drive(($urandom_range(0, 9) == 0), pat[2], pat[1], pat[0],
            ($urandom_range(0, 11) != 0), 2'($urandom_range(0, 3)),
            ($urandom_range(0, 3) == 0), "R1 random mix");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule